// File: doc/BRIEF.md
# Isochronous Ping-Pong IN Endpoint Buffer

This block is the packet store of one isochronous IN endpoint. It holds two packet buffers. During a frame the CPU fills one of them and the USB transmit side drains the other. Each start-of-frame pulse exchanges the two roles. The packet the CPU assembled in one frame is therefore sent in the next. Each buffer keeps its own byte count. At the exchange, the count the CPU built up becomes the length of the packet to send, and the buffer handed to the CPU starts again at zero.

When an IN token for this endpoint finds the transmit-side buffer empty, a shared configuration input decides the answer. The answer is either nothing at all or a zero-length packet. The same input is meant to be wired to every isochronous IN endpoint, numbers 8 to 15. A CPU interrupt follows each exchange after a fixed number of cycles. CPU writes that land in a guard window around the frame boundary are refused and reported, because they could damage a buffer that is changing hands.

Top module: `iso_pingpong_ep`

## Requirements
- R1: After reset, `cpu_sel_o` is 0, which means the CPU owns buffer 0. `tx_valid_o`, `tx_last_o`, `tx_zlp_o`, `sof_irq_o` and `cpu_wr_err_o` are all low.
- R2: Each cycle with `sof_i` high inverts `cpu_sel_o` from the next cycle on. The buffer the CPU owned becomes the transmit buffer.
- R3: `sof_irq_o` is high for exactly one cycle, `IRQ_DLY` cycles after the cycle in which `sof_i` was sampled. A new `sof_i` pulse before then restarts the delay.
- R4: A token (`tok_i` high with `tok_ep_i` equal to `EP_NUM`) that finds a non-empty transmit buffer starts a packet in the next cycle. The packet has one byte per cycle on `tx_data_o`, with `tx_valid_o` high, in address order 0, 1, … up to length−1. The length is one more than the highest address the CPU wrote in that buffer during its frame, whatever the order of the writes.
- R5: `tx_last_o` is high together with the final byte of the packet. After the packet has been sent, the transmit buffer counts as empty for the rest of the frame.
- R6: With `cfg_zlp_en_i` at 0, a token that finds the transmit buffer empty gets no response: `tx_valid_o` and `tx_zlp_o` stay low.
- R7: With `cfg_zlp_en_i` at 1, a token that finds the transmit buffer empty raises `tx_zlp_o` for exactly one cycle, the cycle after the token, while `tx_valid_o` stays low.
- R8: A token whose `tok_ep_i` differs from `EP_NUM` produces neither data nor a zero-length packet.
- R9: Once the first `sof_i` has been seen, a CPU write is refused in three cases: it arrives in a cycle with `sof_i` high, it arrives fewer than `GUARD_POST` cycles after the exchange, or it arrives `FRAME_CYC−GUARD_PRE` or more cycles after the exchange. The cycle count after the exchange is 0 in the first cycle following it. A refused write is not stored, does not change the length, and raises `cpu_wr_err_o` for one cycle in the following cycle. Any other write is stored and raises no error.
- R10: At each exchange, the new transmit buffer takes the CPU-side count as its length, and the buffer handed to the CPU starts with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | One-cycle start-of-frame pulse |
| cfg_zlp_en_i | input | 1 | Answer empty tokens with a zero-length packet when 1 |
| cpu_wr_i | input | 1 | CPU byte write strobe |
| cpu_addr_i | input | $clog2(DEPTH) | CPU byte address in its own buffer |
| cpu_data_i | input | DATA_W | CPU write data |
| cpu_wr_err_o | output | 1 | Pulse: previous write was refused in the guard window |
| cpu_sel_o | output | 1 | Index of the buffer the CPU currently owns |
| sof_irq_o | output | 1 | Delayed start-of-frame interrupt pulse |
| tok_i | input | 1 | Isochronous IN token pulse |
| tok_ep_i | input | 4 | Endpoint number of the token |
| tx_valid_o | output | 1 | Packet byte on `tx_data_o` is valid |
| tx_data_o | output | DATA_W | Packet byte |
| tx_last_o | output | 1 | Final byte of the packet |
| tx_zlp_o | output | 1 | Pulse: send a zero-length packet |

## Verification
The packet path is tried with a buffer filled in scrambled address order, and with a single-byte buffer. These show that the length follows the highest address rather than the number of writes, and that the stream always starts at address 0. Empty-buffer tokens are sent with the enable at 0 and at 1, with the buffer empty either because the packet was already sent or because nothing was written. A token for a different endpoint is sent while data is waiting, which tells a true endpoint filter apart from one that merely has nothing to send. Writes are placed one cycle on each side of both guard edges, and a frame whose packet must contain only the accepted byte shows that a refused write is truly dropped.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_DATA = 1'b1
  } tx_state_e;

  // True when a frame-relative cycle count lies in the unsafe zone
  // around the buffer exchange. Before the first exchange nothing is unsafe.
  function automatic logic in_guard(input logic        seen,
                                    input int unsigned fcnt,
                                    input int unsigned frame_cyc,
                                    input int unsigned pre,
                                    input int unsigned post);
    if (!seen) return 1'b0;
    return (fcnt < post) || (fcnt + pre >= frame_cyc);
  endfunction

  // True when writing byte address addr lengthens a packet of cur bytes.
  function automatic logic extends_len(input int unsigned cur,
                                       input int unsigned addr);
    return (addr + 1) > cur;
  endfunction

endpackage

// File: rtl/iso_pp_frame_ctl.sv
module iso_pp_frame_ctl
  import iso_pp_pkg::*;
#(
  parameter int unsigned FRAME_CYC  = 48000,
  parameter int unsigned GUARD_PRE  = 2400,
  parameter int unsigned GUARD_POST = 2400,
  parameter int unsigned IRQ_DLY    = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sof_i,
  output logic cpu_sel_o,
  output logic guard_o,
  output logic irq_o
);

  localparam int unsigned FW = $clog2(FRAME_CYC + 1);
  localparam int unsigned DW = $clog2(IRQ_DLY + 1);

  logic [FW-1:0] fcnt_q;
  logic          seen_q;
  logic          sel_q;
  logic [DW-1:0] dly_q;
  logic          irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      seen_q <= 1'b0;
      sel_q  <= 1'b0;
      dly_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= (dly_q == DW'(1)) && !sof_i;
      if (sof_i) begin
        fcnt_q <= '0;
        seen_q <= 1'b1;
        sel_q  <= ~sel_q;
        dly_q  <= DW'(IRQ_DLY);
      end else begin
        if (fcnt_q != FW'(FRAME_CYC)) fcnt_q <= fcnt_q + 1'b1;
        if (dly_q != '0)              dly_q  <= dly_q - 1'b1;
      end
    end
  end

  assign guard_o   = sof_i | in_guard(seen_q, 32'(fcnt_q), FRAME_CYC, GUARD_PRE, GUARD_POST);
  assign cpu_sel_o = sel_q;
  assign irq_o     = irq_q;

  AST_SEL_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (cpu_sel_o != $past(cpu_sel_o)));                           // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);                                                    // R3
  AST_NO_SWAP_WITHOUT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_i |=> $stable(cpu_sel_o));                                       // R2

endmodule

// File: rtl/iso_pp_bank.sv
module iso_pp_bank
  import iso_pp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        swap_i,
  input  logic                        cpu_sel_i,
  input  logic                        wr_en_i,
  input  logic [$clog2(DEPTH)-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic                        consume_i,
  input  logic [$clog2(DEPTH)-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]  usb_len_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     len_w  [2];
  logic [DATA_W-1:0] rdat_w [2];
  logic [CW-1:0]     cpu_len_w;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CW-1:0]     cnt_q;
    logic              cpu_own;

    assign cpu_own = (cpu_sel_i == 1'(b));

    always_ff @(posedge clk) begin
      if (wr_en_i && cpu_own) mem[wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (swap_i) begin
        if (!cpu_own) cnt_q <= '0;
      end else if (consume_i && !cpu_own) begin
        cnt_q <= '0;
      end else if (wr_en_i && cpu_own && extends_len(32'(cnt_q), 32'(wr_addr_i))) begin
        cnt_q <= CW'(wr_addr_i) + CW'(1);
      end
    end

    assign len_w[b]  = cnt_q;
    assign rdat_w[b] = mem[rd_addr_i];
  end

  assign usb_len_o = len_w[~cpu_sel_i];
  assign rd_data_o = rdat_w[~cpu_sel_i];
  assign cpu_len_w = len_w[cpu_sel_i];

  AST_CPU_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> (cpu_len_w == '0));                                        // R10
  AST_LEN_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> (usb_len_o == $past(cpu_len_w)));                          // R10
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_len_w <= CW'(DEPTH));                                             // R4

  localparam int unsigned UNUSED_AW = AW;

endmodule

// File: rtl/iso_pp_tx.sv
module iso_pp_tx
  import iso_pp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned EP_NUM = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tok_i,
  input  logic [3:0]                  tok_ep_i,
  input  logic                        zlp_en_i,
  input  logic                        swap_i,
  input  logic [$clog2(DEPTH+1)-1:0]  usb_len_i,
  input  logic [DATA_W-1:0]           rd_data_i,
  output logic [$clog2(DEPTH)-1:0]    rd_addr_o,
  output logic                        consume_o,
  output logic                        tx_valid_o,
  output logic [DATA_W-1:0]           tx_data_o,
  output logic                        tx_last_o,
  output logic                        tx_zlp_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  tx_state_e     state_q;
  logic [AW-1:0] ptr_q;
  logic          zlp_q;
  logic          ep_hit_w;
  logic          is_last_w;

  assign ep_hit_w  = tok_i && (tok_ep_i == 4'(EP_NUM));
  assign is_last_w = (state_q == TX_DATA) && ((CW'(ptr_q) + CW'(1)) == usb_len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      ptr_q   <= '0;
      zlp_q   <= 1'b0;
    end else begin
      zlp_q <= 1'b0;
      case (state_q)
        TX_IDLE: begin
          if (ep_hit_w && !swap_i) begin
            if (usb_len_i != '0) begin
              state_q <= TX_DATA;
              ptr_q   <= '0;
            end else if (zlp_en_i) begin
              zlp_q <= 1'b1;
            end
          end
        end
        default: begin
          if (swap_i || is_last_w) state_q <= TX_IDLE;
          else                     ptr_q   <= ptr_q + 1'b1;
        end
      endcase
    end
  end

  assign consume_o  = is_last_w && !swap_i;
  assign rd_addr_o  = ptr_q;
  assign tx_valid_o = (state_q == TX_DATA);
  assign tx_data_o  = rd_data_i;
  assign tx_last_o  = is_last_w;
  assign tx_zlp_o   = zlp_q;

  AST_ZLP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp_o |-> $past(zlp_en_i));                                        // R6
  AST_ZLP_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp_o |-> ($past(usb_len_i) == '0));                               // R7
  AST_ZLP_NOT_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp_o |-> !tx_valid_o);                                            // R7
  AST_ZLP_OWN_EP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp_o |-> $past(tok_ep_i) == 4'(EP_NUM));                          // R8
  AST_STREAM_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid_o) |-> (rd_addr_o == '0));                             // R4
  AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && $past(tx_valid_o) && !$past(tx_last_o))
      |-> (rd_addr_o == AW'($past(rd_addr_o) + 1'b1)));                   // R4

endmodule

// File: rtl/iso_pingpong_ep.sv
module iso_pingpong_ep
  import iso_pp_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned EP_NUM     = 8,
  parameter int unsigned FRAME_CYC  = 48000,
  parameter int unsigned GUARD_PRE  = 2400,
  parameter int unsigned GUARD_POST = 2400,
  parameter int unsigned IRQ_DLY    = 480
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sof_i,
  input  logic                     cfg_zlp_en_i,
  input  logic                     cpu_wr_i,
  input  logic [$clog2(DEPTH)-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0]        cpu_data_i,
  output logic                     cpu_wr_err_o,
  output logic                     cpu_sel_o,
  output logic                     sof_irq_o,
  input  logic                     tok_i,
  input  logic [3:0]               tok_ep_i,
  output logic                     tx_valid_o,
  output logic [DATA_W-1:0]        tx_data_o,
  output logic                     tx_last_o,
  output logic                     tx_zlp_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic              guard_w;
  logic              wr_ok_w;
  logic              consume_w;
  logic [AW-1:0]     rd_addr_w;
  logic [DATA_W-1:0] rd_data_w;
  logic [CW-1:0]     usb_len_w;
  logic              err_q;

  iso_pp_frame_ctl #(
    .FRAME_CYC (FRAME_CYC),
    .GUARD_PRE (GUARD_PRE),
    .GUARD_POST(GUARD_POST),
    .IRQ_DLY   (IRQ_DLY)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof_i    (sof_i),
    .cpu_sel_o(cpu_sel_o),
    .guard_o  (guard_w),
    .irq_o    (sof_irq_o)
  );

  assign wr_ok_w = cpu_wr_i && !guard_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cpu_wr_i && guard_w;
  end
  assign cpu_wr_err_o = err_q;

  iso_pp_bank #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap_i   (sof_i),
    .cpu_sel_i(cpu_sel_o),
    .wr_en_i  (wr_ok_w),
    .wr_addr_i(cpu_addr_i),
    .wr_data_i(cpu_data_i),
    .consume_i(consume_w),
    .rd_addr_i(rd_addr_w),
    .rd_data_o(rd_data_w),
    .usb_len_o(usb_len_w)
  );

  iso_pp_tx #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .EP_NUM(EP_NUM)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_i     (tok_i),
    .tok_ep_i  (tok_ep_i),
    .zlp_en_i  (cfg_zlp_en_i),
    .swap_i    (sof_i),
    .usb_len_i (usb_len_w),
    .rd_data_i (rd_data_w),
    .rd_addr_o (rd_addr_w),
    .consume_o (consume_w),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .tx_last_o (tx_last_o),
    .tx_zlp_o  (tx_zlp_o)
  );

  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_err_o |-> $past(cpu_wr_i));                                    // R9
  AST_ERR_ON_SOF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && cpu_wr_i) |=> cpu_wr_err_o);                                // R9
  AST_LAST_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> tx_valid_o);                                            // R5
  AST_EMPTY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last_o && !sof_i) |=> (usb_len_w == '0));                         // R5

endmodule

// File: tb/iso_pingpong_ep_bench.sv
`timescale 1ns/1ps
module iso_pingpong_ep_bench;

  localparam int DEPTH = 16;
  localparam int FRAME = 100;
  localparam int GPRE  = 5;
  localparam int GPOST = 6;
  localparam int IDLY  = 10;
  localparam int EP    = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0;
  logic       zlp_en = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_data = '0;
  logic       tok = 1'b0;
  logic [3:0] tok_ep = '0;
  logic       wr_err, cpu_sel, irq, tx_valid, tx_last, tx_zlp;
  logic [7:0] tx_data;

  int n_chk = 0;
  int n_bad = 0;
  int fc = 0;
  logic [7:0] pkt_q [$];

  always #2.5 clk = ~clk;

  iso_pingpong_ep #(
    .DATA_W(8), .DEPTH(DEPTH), .EP_NUM(EP), .FRAME_CYC(FRAME),
    .GUARD_PRE(GPRE), .GUARD_POST(GPOST), .IRQ_DLY(IDLY)
  ) u_iso_pingpong_ep (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .cfg_zlp_en_i(zlp_en),
    .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_wr_err_o(wr_err), .cpu_sel_o(cpu_sel), .sof_irq_o(irq),
    .tok_i(tok), .tok_ep_i(tok_ep), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_zlp_o(tx_zlp)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    fc++;
  endtask

  task automatic pulse_sof();
    sof = 1'b1;
    step();
    sof = 1'b0;
    fc = 0;
  endtask

  task automatic wr(input int addr, input int data, input int exp_err, input string req);
    cpu_wr = 1'b1; cpu_addr = 4'(addr); cpu_data = 8'(data);
    step();
    cpu_wr = 1'b0;
    check(req, "wr_err", int'(wr_err), exp_err);
  endtask

  task automatic token(input int ep);
    tok = 1'b1; tok_ep = 4'(ep);
    step();
    tok = 1'b0;
  endtask

  task automatic expect_packet(input string req);
    for (int i = 0; i < pkt_q.size(); i++) begin
      check(req, "tx_valid", int'(tx_valid), 1);
      check(req, "tx_data", int'(tx_data), int'(pkt_q[i]));
      check("R5", "tx_last", int'(tx_last), (i == pkt_q.size() - 1) ? 1 : 0);
      step();
    end
    check(req, "tx_valid after packet", int'(tx_valid), 0);
  endtask

  task automatic expect_silence(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      check(req, "tx_valid", int'(tx_valid), 0);
      check(req, "tx_zlp", int'(tx_zlp), 0);
      step();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1", "cpu_sel", int'(cpu_sel), 0);
    check("R1", "tx_valid", int'(tx_valid), 0);
    check("R1", "tx_zlp", int'(tx_zlp), 0);
    check("R1", "sof_irq", int'(irq), 0);
    check("R1", "wr_err", int'(wr_err), 0);
  endtask

  task automatic t_swap_stream();
    int irq_at = -1;
    int irq_n = 0;
    wr(3, 'hA3, 0, "R9");
    wr(0, 'hA0, 0, "R9");
    wr(2, 'hA2, 0, "R9");
    wr(1, 'hA1, 0, "R9");
    pulse_sof();
    check("R2", "cpu_sel after first swap", int'(cpu_sel), 1);
    for (int k = 0; k < IDLY + 3; k++) begin
      step();
      if (irq) begin
        irq_n++;
        if (irq_at < 0) irq_at = fc;
      end
    end
    check("R3", "irq delay", irq_at, IDLY);
    check("R3", "irq pulse count", irq_n, 1);
    token(EP);
    pkt_q = {8'hA0, 8'hA1, 8'hA2, 8'hA3};
    expect_packet("R4");
    zlp_en = 1'b0;
    token(EP);
    expect_silence("R6", 3);
  endtask

  task automatic t_empty_zlp();
    zlp_en = 1'b1;
    token(EP);
    check("R7", "tx_zlp", int'(tx_zlp), 1);
    check("R7", "tx_valid with zlp", int'(tx_valid), 0);
    step();
    check("R7", "tx_zlp one cycle", int'(tx_zlp), 0);
    token(3);
    expect_silence("R8", 2);
  endtask

  task automatic t_guard();
    while (fc < FRAME - GPRE - 1) step();
    wr(0, 'h55, 0, "R9");
    wr(1, 'h66, 1, "R9");
    while (fc < FRAME + 3) step();
    pulse_sof();
    check("R2", "cpu_sel second swap", int'(cpu_sel), 0);
    while (fc < GPOST - 1) step();
    wr(2, 'h88, 1, "R9");
    wr(0, 'h77, 0, "R9");
    token(EP);
    pkt_q = {8'h55};
    expect_packet("R9");
  endtask

  task automatic t_count_clear();
    pulse_sof();
    check("R2", "cpu_sel third swap", int'(cpu_sel), 1);
    zlp_en = 1'b0;
    token(3);
    expect_silence("R8", 2);
    token(EP);
    pkt_q = {8'h77};
    expect_packet("R10");
    pulse_sof();
    zlp_en = 1'b1;
    token(EP);
    check("R10", "zlp on cleared buffer", int'(tx_zlp), 1);
    check("R10", "no data on cleared buffer", int'(tx_valid), 0);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_swap_stream();
    t_empty_zlp();
    t_guard();
    t_count_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule